// File: doc/BRIEF.md
# Configurable Register Output Macrocell

This block is one logic cell that sits at the output of a programmable sum-of-products array. From the array it receives a data sum term, an enable/clock sum term, a reset product term and an output-enable product term. It turns them into a feedback bit that goes back into the array and a pin-side level that goes to an inverting three-state driver. The pad itself sits outside the block, so the driver appears as two signals: a level and a drive enable.

Two static configuration bits choose how the cell behaves. It can be a plain combinational path. It can be a D flip-flop whose clock is the enable term itself. It can be a D flip-flop on the shared output clock whose load is gated by the enable term. Two more static bits invert the data term and the enable term before they are used. Both registers clear asynchronously while the reset term is high, and that clear takes priority over any clock edge.

Top module: `outmacro_cell`

## Requirements
- R1: With cfg_mode 2'b00 or 2'b11 (combinational), feedback equals d_sum XOR cfg_d_inv at all times, with no clock involved.
- R2: With cfg_mode 2'b10 (gated register), at a rising edge of oclk where (e_sum XOR cfg_e_inv) is 1, the register takes (d_sum XOR cfg_d_inv) and feedback shows it after that edge.
- R3: With cfg_mode 2'b10, at a rising oclk edge where (e_sum XOR cfg_e_inv) is 0, the register keeps its value.
- R4: With cfg_mode 2'b01 (term clock), the register takes (d_sum XOR cfg_d_inv) on each rising edge of (e_sum XOR cfg_e_inv); edges of oclk have no effect on it.
- R5: While rst_term is 1, the register of the active registered mode is 0, even when rst_term rises between clock edges. A clock or enable-term edge that occurs while rst_term is 1 does not load it. This holds in both registered modes.
- R6: pin_level is always the inverse of feedback, so a cleared register shows as 1 on pin_level.
- R7: pin_drive equals oe_term. feedback does not depend on oe_term.
- R8: In both registered modes feedback is the register state, taken before the output driver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oclk | input | 1 | Shared output clock for the gated register mode |
| rst_term | input | 1 | Active-high asynchronous clear product term |
| d_sum | input | 1 | Data sum term from the array |
| e_sum | input | 1 | Enable or clock sum term from the array |
| oe_term | input | 1 | Output-enable product term for the pin driver |
| cfg_mode | input | 2 | Mode: 00/11 combinational, 01 term clock, 10 gated register |
| cfg_d_inv | input | 1 | Inverts the data term when 1 |
| cfg_e_inv | input | 1 | Inverts the enable/clock term when 1 |
| pin_level | output | 1 | Inverted level presented to the three-state pin driver |
| pin_drive | output | 1 | Drive enable for the pin driver (1 = driven) |
| feedback | output | 1 | Cell value returned to the array, taken before the driver |

## Verification
Two functions can fall in the same cycle: the asynchronous clear and a register load. In the gated mode, the bench holds rst_term high across an oclk edge while the enable term is true and the data term is 1. In the term-clock mode, it raises the enable term while rst_term is high. In both cases feedback must stay 0 and pin_level 1, and the register must load normally at the first edge after release. The bench also raises rst_term between clock edges and samples feedback before the next edge to show that the clear does not wait for a clock.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MC_COMB     = 2'b00,
    MC_TERMCLK  = 2'b01,
    MC_GATED    = 2'b10,
    MC_COMB_ALT = 2'b11
  } mc_mode_e;

  localparam logic MC_CLEAR_VAL = 1'b0;
endpackage

// File: rtl/mc_polarity.sv
module mc_polarity #(
  parameter int W = 1
) (
  input  logic [W-1:0] raw,
  input  logic         inv,
  output logic [W-1:0] pol
);
  always_comb pol = raw ^ {W{inv}};
endmodule

// File: rtl/mc_dreg.sv
module mc_dreg #(
  parameter bit USE_ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  import mc_pkg::*;

  generate
    if (USE_ENABLE) begin : g_gated
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     q <= MC_CLEAR_VAL;
        else if (en) q <= d;
      end

      // R2: an enabled edge loads the data term
      a_r2_gated_load: assert property (@(posedge clk) disable iff (rst)
        en |=> (q == $past(d)));
      // R3: a disabled edge keeps the state
      a_r3_gated_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));
    end else begin : g_plain
      always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= MC_CLEAR_VAL;
        else     q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage (
  input  logic fb_in,
  input  logic oe_in,
  output logic level_out,
  output logic drive_out
);
  always_comb begin
    level_out = ~fb_in;
    drive_out = oe_in;
  end
endmodule

// File: rtl/outmacro_cell.sv
module outmacro_cell (
  input  logic       oclk,
  input  logic       rst_term,
  input  logic       d_sum,
  input  logic       e_sum,
  input  logic       oe_term,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_d_inv,
  input  logic       cfg_e_inv,
  output logic       pin_level,
  output logic       pin_drive,
  output logic       feedback
);
  import mc_pkg::*;

  logic d_pol, e_pol;
  logic is_term, is_gated;
  logic term_clk, gated_en;
  logic q_term, q_gated;

  mc_polarity #(.W(1)) u_dpol (.raw(d_sum), .inv(cfg_d_inv), .pol(d_pol));
  mc_polarity #(.W(1)) u_epol (.raw(e_sum), .inv(cfg_e_inv), .pol(e_pol));

  always_comb begin
    is_term  = (cfg_mode == MC_TERMCLK);
    is_gated = (cfg_mode == MC_GATED);
    term_clk = is_term & e_pol;
    gated_en = is_gated & e_pol;
  end

  mc_dreg #(.USE_ENABLE(1'b0)) u_term_reg (
    .clk(term_clk), .rst(rst_term), .en(1'b1), .d(d_pol), .q(q_term));

  mc_dreg #(.USE_ENABLE(1'b1)) u_gated_reg (
    .clk(oclk), .rst(rst_term), .en(gated_en), .d(d_pol), .q(q_gated));

  always_comb begin
    unique case (cfg_mode)
      MC_TERMCLK: feedback = q_term;
      MC_GATED:   feedback = q_gated;
      default:    feedback = d_pol;
    endcase
  end

  mc_out_stage u_out (
    .fb_in(feedback), .oe_in(oe_term),
    .level_out(pin_level), .drive_out(pin_drive));

  // R6: the pin level is the inverse of the feedback
  a_r6_pin_inverts: assert property (@(posedge oclk) disable iff (rst_term)
    pin_level == !feedback);
  // R1: combinational modes pass the polarised data term
  a_r1_comb_path: assert property (@(posedge oclk) disable iff (rst_term)
    (cfg_mode == MC_COMB || cfg_mode == MC_COMB_ALT) |-> (feedback == (d_sum ^ cfg_d_inv)));
  // R7: drive follows the output-enable term
  a_r7_drive: assert property (@(posedge oclk) disable iff (rst_term)
    pin_drive == oe_term);
endmodule

// File: tb/sim_outmacro_cell.sv
module sim_outmacro_cell;
  logic       oclk = 1'b0;
  logic       rst_term = 1'b1;
  logic       d_sum = 1'b0, e_sum = 1'b0, oe_term = 1'b0;
  logic [1:0] cfg_mode = 2'b10;
  logic       cfg_d_inv = 1'b0, cfg_e_inv = 1'b0;
  logic       pin_level, pin_drive, feedback;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic model;

  always #4 oclk = ~oclk;

  outmacro_cell u0 (
    .oclk(oclk), .rst_term(rst_term), .d_sum(d_sum), .e_sum(e_sum),
    .oe_term(oe_term), .cfg_mode(cfg_mode), .cfg_d_inv(cfg_d_inv),
    .cfg_e_inv(cfg_e_inv), .pin_level(pin_level), .pin_drive(pin_drive),
    .feedback(feedback));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input string req, input logic exp_fb);
    check(req, feedback, exp_fb);
    check({req, "/R6"}, pin_level, ~exp_fb);
  endtask

  // reset spanning two oclk edges so no registered state moves between edges
  task automatic full_reset();
    @(negedge oclk); rst_term = 1'b1;
    @(posedge oclk); @(posedge oclk);
    @(negedge oclk); rst_term = 1'b0;
  endtask

  // rising edge on the polarised enable term
  task automatic term_edge(input logic d, input logic di, input logic ei);
    cfg_e_inv = ei; #1;
    e_sum = ei;     #1;
    cfg_d_inv = di; d_sum = d; #1;
    e_sum = ~ei;    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // reset state (R5, R6)
    @(posedge oclk); @(posedge oclk); #1;
    check_out("R5 reset state", 1'b0);
    @(negedge oclk); rst_term = 1'b0;

    // R1, R6, R7: combinational sweep over both encodings
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 32; v++) begin
        @(negedge oclk);
        cfg_mode  = (m == 0) ? 2'b00 : 2'b11;
        cfg_d_inv = v[0]; cfg_e_inv = v[1];
        d_sum = v[2]; e_sum = v[3]; oe_term = v[4];
        #1;
        check_out("R1 comb", v[2] ^ v[0]);
        check("R7 drive", pin_drive, v[4]);
      end

    // R2, R3, R7, R8: gated register sweep
    @(negedge oclk); cfg_mode = 2'b10; e_sum = 1'b0; cfg_e_inv = 1'b0;
    full_reset();
    model = 1'b0;
    for (int rep = 0; rep < 3; rep++)
      for (int v = 0; v < 32; v++) begin
        @(negedge oclk);
        cfg_d_inv = v[0]; cfg_e_inv = v[1];
        d_sum = v[2] ^ rep[0]; e_sum = v[3]; oe_term = v[4];
        @(posedge oclk); #1;
        if (v[3] ^ v[1]) model = (v[2] ^ rep[0]) ^ v[0];
        check_out((v[3] ^ v[1]) ? "R2 gated load" : "R3 gated hold", model);
        check("R7 drive", pin_drive, v[4]);
      end

    // R5: clear held over an enabled oclk edge, then normal load after release
    @(negedge oclk); cfg_d_inv = 1'b0; cfg_e_inv = 1'b0; e_sum = 1'b0; d_sum = 1'b0;
    @(negedge oclk); e_sum = 1'b1; d_sum = 1'b1;
    @(posedge oclk); #1; check_out("R2 preload", 1'b1);
    #1 rst_term = 1'b1; #1;
    check_out("R5 async clear mid-cycle gated", 1'b0);
    @(posedge oclk); #1; check_out("R5 clear beats enabled edge gated", 1'b0);
    @(posedge oclk); #1; check_out("R5 clear beats enabled edge gated", 1'b0);
    @(negedge oclk); rst_term = 1'b0; #1;
    check_out("R5 no load at release", 1'b0);
    @(posedge oclk); #1; check_out("R5 load after release gated", 1'b1);

    // R4, R8: term-clock register
    @(negedge oclk); cfg_mode = 2'b01; e_sum = 1'b0; cfg_e_inv = 1'b0;
    full_reset();
    for (int v = 0; v < 8; v++) begin
      @(negedge oclk);
      term_edge(v[0], v[1], v[2]);
      check_out("R4 term edge load", v[0] ^ v[1]);
      d_sum = ~v[0];
      @(posedge oclk); @(posedge oclk); #1;
      check_out("R4 oclk ignored", v[0] ^ v[1]);
      e_sum = v[2]; #1;
      check_out("R4 falling term edge ignored", v[0] ^ v[1]);
    end

    // R5: clear against a term-clock edge
    @(negedge oclk); term_edge(1'b1, 1'b0, 1'b0);
    check_out("R4 preload", 1'b1);
    rst_term = 1'b1; #1;
    check_out("R5 async clear term mode", 1'b0);
    e_sum = 1'b0; #1; e_sum = 1'b1; #1;
    check_out("R5 clear beats term edge", 1'b0);
    @(posedge oclk); @(posedge oclk);
    @(negedge oclk); rst_term = 1'b0; #1;
    check_out("R5 no load at release term", 1'b0);
    e_sum = 1'b0; #1; e_sum = 1'b1; #1;
    check_out("R5 load after release term", 1'b1);
    oe_term = 1'b0; #1;
    check_out("R7 feedback without drive", 1'b1);
    check("R7 drive off", pin_drive, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule